// File: doc/BRIEF.md
# DMA Channel Request Sequencer

This block runs the control side of one DMA channel. A start comes either from a software trigger flag or from one of several hardware request lines, picked by a source-select field. Each start wins the bus through a request/grant pair. The block then runs one atomic transfer through a beat handshake and gives the bus back. An atomic transfer is one beat or a burst of four beats. The block also keeps the current transfer count. Address generation, the data path and arbitration between masters are not part of this block.

There are two service modes. In per-request mode, each accepted start moves exactly one atomic transfer. In whole-count mode, one start repeats atomic transfers until the current count reaches zero. The bus is handed back after every atomic transfer in both modes. When the count reaches zero, a one-cycle terminal pulse is raised. Depending on the stop option, the channel then either stays armed for a reload on the next start, or switches itself off.

Top module: `dma_chan_seq`

## Requirements
- R1: After reset, `bus_req`, `beat_req`, `chan_on`, `sw_pend`, `tc_irq` and `cur_cnt` are all zero.
- R2: With `cfg_hw_trig`=0, a pulse on `sw_trig_set` sets `sw_pend`. The pending flag starts a transfer once `chan_on` is 1, and it clears when the start is accepted. While the channel is off, the flag stays set.
- R3: With `cfg_hw_trig`=1, only `hw_req[cfg_src_sel]` can start a transfer, and every other request line has no effect. With `cfg_hw_trig`=0, `cfg_src_sel` is ignored and raises no error even at code 7.
- R4: An atomic transfer raises `bus_req` and waits for `bus_gnt`. It then holds `beat_req` for 4 completed beats if `cfg_burst4`=1, or 1 beat if it is 0. `beat_req` is only ever high while `bus_req` is high.
- R5: `bus_req` drops in the cycle after the last beat completes. This happens after every atomic transfer, including inside a whole-count run.
- R6: With `cfg_whole`=0, each accepted start moves exactly one atomic transfer, and the channel then waits for a new start.
- R7: With `cfg_whole`=1, one accepted start repeats atomic transfers until `cur_cnt` reaches zero.
- R8: `cfg_init_cnt` is copied into `cur_cnt` only when a start is accepted while `cur_cnt` is zero. `cur_cnt` drops by one per completed atomic transfer, not per beat, and otherwise holds.
- R9: `tc_irq` is high for exactly one cycle: the first cycle after the transfer that brings `cur_cnt` to zero, which is also the cycle in which `bus_req` is low.
- R10: With `cfg_stop_at_tc`=0, `chan_on` stays set at zero count, and the next start reloads the count. With `cfg_stop_at_tc`=1, `chan_on` clears in the same cycle as `tc_irq`.
- R11: `cfg_err` is 1 when `cfg_dsize`=2'b11, or when `cfg_hw_trig`=1 and `cfg_src_sel`≥7. While `cfg_err` is 1, no transfer starts, and a pending software start is kept.
- R12: `beat_bytes` reports 1, 2 and 4 for `cfg_dsize` 2'b00, 2'b01 and 2'b10, and 0 for the reserved code 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_whole | input | 1 | 1: whole-count mode, 0: per-request mode |
| cfg_hw_trig | input | 1 | 1: start from a hardware line, 0: start from the software flag |
| cfg_src_sel | input | 3 | Hardware request line select |
| cfg_stop_at_tc | input | 1 | 1: clear `chan_on` at zero count, 0: auto-reload |
| cfg_dsize | input | 2 | Beat data size code |
| cfg_burst4 | input | 1 | 1: four-beat burst, 0: single beat |
| cfg_init_cnt | input | 20 | Initial transfer count |
| chan_on_set | input | 1 | Pulse that switches the channel on |
| sw_trig_set | input | 1 | Pulse that sets the software start flag |
| hw_req | input | 7 | Hardware request lines |
| bus_gnt | input | 1 | Bus grant |
| beat_done | input | 1 | Current beat completed |
| bus_req | output | 1 | Bus request |
| beat_req | output | 1 | Beat request |
| beat_bytes | output | 3 | Bytes per beat |
| chan_on | output | 1 | Channel enabled |
| sw_pend | output | 1 | Software start pending |
| cur_cnt | output | 20 | Current transfer count |
| tc_irq | output | 1 | Terminal count pulse |
| cfg_err | output | 1 | Reserved configuration detected |

## Verification
If the beat counter is off, the number of `beat_req` cycles between a rise and the next fall of `bus_req` comes out wrong, and this shows within the same transfer. If the count register is off, it shows at the very next bus release, where `cur_cnt`, `tc_irq` and `chan_on` are compared against a scoreboard entry. If the mode or source decode is off, it shows as a transfer that should not happen, or as a missing one. The monitor catches the first as a transfer with no scoreboard entry. It catches the second as an entry left over once the idle window after each stimulus has passed.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_BUSREQ = 2'd1,
      ST_BEAT   = 2'd2,
      ST_REL    = 2'd3
   } seq_state_t;

   typedef enum logic [1:0] {
      DS_BYTE = 2'b00,
      DS_HALF = 2'b01,
      DS_WORD = 2'b10,
      DS_RSVD = 2'b11
   } dsize_t;

   function automatic logic [2:0] dsize_bytes(input logic [1:0] code);
      case (code)
         DS_BYTE: dsize_bytes = 3'd1;
         DS_HALF: dsize_bytes = 3'd2;
         DS_WORD: dsize_bytes = 3'd4;
         default: dsize_bytes = 3'd0;
      endcase
   endfunction
endpackage

// File: rtl/dma_req_mux.sv
module dma_req_mux #(
   parameter int N_SRC = 7,
   parameter int SEL_W = 3
) (
   input  logic [N_SRC-1:0] req_in,
   input  logic [SEL_W-1:0] sel,
   output logic             req_out,
   output logic             sel_valid
);
   if (N_SRC > (1 << SEL_W)) begin : g_bad_width
      $error("dma_req_mux: select too narrow for N_SRC");
   end

   logic [N_SRC-1:0] hit;

   for (genvar i = 0; i < N_SRC; i++) begin : g_src
      assign hit[i] = req_in[i] && (sel == SEL_W'(i));
   end

   assign req_out   = |hit;
   assign sel_valid = (32'(sel) < N_SRC);
endmodule

// File: rtl/dma_tc_counter.sv
module dma_tc_counter #(
   parameter int CNT_W = 20
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_ack,
   input  logic             xfer_done,
   input  logic [CNT_W-1:0] init_cnt,
   output logic [CNT_W-1:0] cur_cnt,
   output logic             zero_hit
);
   if (CNT_W < 2) begin : g_bad_cnt
      $error("dma_tc_counter: CNT_W must be at least 2");
   end

   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic [CNT_W-1:0] cnt_q;
   logic             is_zero;

   assign is_zero  = (cnt_q == '0);
   assign zero_hit = xfer_done && (cnt_q <= ONE);
   assign cur_cnt  = cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (start_ack && is_zero) begin
         cnt_q <= init_cnt;
      end else if (xfer_done && !is_zero) begin
         cnt_q <= cnt_q - ONE;
      end
   end

   AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!start_ack && !xfer_done) |=> $stable(cnt_q)); // R8
   AST_LOAD_ONLY_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (start_ack && !is_zero) |=> (cnt_q == $past(cnt_q))); // R8
endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq
   import dma_seq_pkg::*;
#(
   parameter int CNT_W     = 20,
   parameter int N_SRC     = 7,
   parameter int SEL_W     = 3,
   parameter int BURST_LEN = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_whole,
   input  logic             cfg_hw_trig,
   input  logic [SEL_W-1:0] cfg_src_sel,
   input  logic             cfg_stop_at_tc,
   input  logic [1:0]       cfg_dsize,
   input  logic             cfg_burst4,
   input  logic [CNT_W-1:0] cfg_init_cnt,
   input  logic             chan_on_set,
   input  logic             sw_trig_set,
   input  logic [N_SRC-1:0] hw_req,
   input  logic             bus_gnt,
   input  logic             beat_done,
   output logic             bus_req,
   output logic             beat_req,
   output logic [2:0]       beat_bytes,
   output logic             chan_on,
   output logic             sw_pend,
   output logic [CNT_W-1:0] cur_cnt,
   output logic             tc_irq,
   output logic             cfg_err
);
   localparam int BCNT_W = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1;
   localparam logic [BCNT_W-1:0] LAST_BEAT = BCNT_W'(BURST_LEN - 1);

   if (BURST_LEN < 1) begin : g_bad_burst
      $error("dma_chan_seq: BURST_LEN must be positive");
   end

   seq_state_t        state_q, state_d;
   logic [BCNT_W-1:0] beat_q;
   logic              hw_hit, src_ok, trig, accept;
   logic              last_beat, xfer_done, zero_hit;
   logic              on_q, pend_q, tc_q;

   dma_req_mux #(.N_SRC(N_SRC), .SEL_W(SEL_W)) u_mux (
      .req_in    (hw_req),
      .sel       (cfg_src_sel),
      .req_out   (hw_hit),
      .sel_valid (src_ok)
   );

   dma_tc_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_ack (accept),
      .xfer_done (xfer_done),
      .init_cnt  (cfg_init_cnt),
      .cur_cnt   (cur_cnt),
      .zero_hit  (zero_hit)
   );

   assign cfg_err = (cfg_dsize == DS_RSVD) || (cfg_hw_trig && !src_ok);
   assign trig    = cfg_hw_trig ? hw_hit : pend_q;
   assign accept  = (state_q == ST_IDLE) && on_q && !cfg_err && trig;

   if (BURST_LEN > 1) begin : g_burst
      assign last_beat = cfg_burst4 ? (beat_q == LAST_BEAT) : 1'b1;
   end else begin : g_single
      assign last_beat = 1'b1;
   end

   assign xfer_done = (state_q == ST_BEAT) && beat_done && last_beat;

   always_comb begin
      state_d = state_q;
      case (state_q)
         ST_IDLE:   if (accept) state_d = ST_BUSREQ;
         ST_BUSREQ: if (bus_gnt) state_d = ST_BEAT;
         ST_BEAT:   if (xfer_done) state_d = ST_REL;
         ST_REL:    state_d = (cfg_whole && on_q && cur_cnt != '0) ? ST_BUSREQ : ST_IDLE;
         default:   state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         beat_q  <= '0;
         on_q    <= 1'b0;
         pend_q  <= 1'b0;
         tc_q    <= 1'b0;
      end else begin
         state_q <= state_d;
         tc_q    <= zero_hit;
         if (state_q != ST_BEAT || xfer_done) beat_q <= '0;
         else if (beat_done) beat_q <= beat_q + BCNT_W'(1);
         if (zero_hit && cfg_stop_at_tc) on_q <= 1'b0;
         else if (chan_on_set) on_q <= 1'b1;
         if (accept && !cfg_hw_trig) pend_q <= 1'b0;
         else if (sw_trig_set) pend_q <= 1'b1;
      end
   end

   assign bus_req    = (state_q == ST_BUSREQ) || (state_q == ST_BEAT);
   assign beat_req   = (state_q == ST_BEAT);
   assign beat_bytes = dsize_bytes(cfg_dsize);
   assign chan_on    = on_q;
   assign sw_pend    = pend_q;
   assign tc_irq     = tc_q;

   AST_BEAT_UNDER_BUS: assert property (@(posedge clk) disable iff (!rst_n)
      beat_req |-> bus_req); // R4
   AST_BUS_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      (beat_req && beat_done && last_beat) |=> !bus_req); // R5
   AST_TC_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      tc_irq |=> !tc_irq); // R9
   AST_TC_IN_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      tc_irq |-> !bus_req); // R9
   AST_STOP_CLEARS_ON: assert property (@(posedge clk) disable iff (!rst_n)
      (tc_irq && $past(cfg_stop_at_tc)) |-> !chan_on); // R10
   AST_ERR_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_err && !bus_req && !chan_on_set) |=> !bus_req); // R11
   AST_PEND_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(sw_pend)) |-> bus_req); // R2
endmodule

// File: tb/sim_dma_chan_seq.sv
module sim_dma_chan_seq;
   typedef struct {
      int cnt;
      bit tc;
      bit on;
      int beats;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_whole = 1'b0, cfg_hw_trig = 1'b0, cfg_stop_at_tc = 1'b0, cfg_burst4 = 1'b0;
   logic [2:0]  cfg_src_sel = 3'd0;
   logic [1:0]  cfg_dsize = 2'b00;
   logic [19:0] cfg_init_cnt = 20'd0;
   logic        chan_on_set = 1'b0, sw_trig_set = 1'b0;
   logic [6:0]  hw_req = 7'd0;
   logic        bus_gnt = 1'b0, beat_done = 1'b0;
   logic        bus_req, beat_req, chan_on, sw_pend, tc_irq, cfg_err;
   logic [2:0]  beat_bytes;
   logic [19:0] cur_cnt;

   int   vecs = 0, errs = 0, xfers = 0;
   exp_t sb[$];
   bit   finished = 1'b0;

   always #10 clk = ~clk;

   dma_chan_seq u0 (
      .clk(clk), .rst_n(rst_n), .cfg_whole(cfg_whole), .cfg_hw_trig(cfg_hw_trig),
      .cfg_src_sel(cfg_src_sel), .cfg_stop_at_tc(cfg_stop_at_tc), .cfg_dsize(cfg_dsize),
      .cfg_burst4(cfg_burst4), .cfg_init_cnt(cfg_init_cnt), .chan_on_set(chan_on_set),
      .sw_trig_set(sw_trig_set), .hw_req(hw_req), .bus_gnt(bus_gnt), .beat_done(beat_done),
      .bus_req(bus_req), .beat_req(beat_req), .beat_bytes(beat_bytes), .chan_on(chan_on),
      .sw_pend(sw_pend), .cur_cnt(cur_cnt), .tc_irq(tc_irq), .cfg_err(cfg_err)
   );

   task automatic check(input string req, input int act, input int exp);
      vecs++;
      if (act != exp) begin
         errs++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic push(input int cnt, input bit tc, input bit on, input int beats);
      exp_t e;
      e.cnt = cnt; e.tc = tc; e.on = on; e.beats = beats;
      sb.push_back(e);
   endtask

   task automatic pulse_on();
      @(negedge clk) chan_on_set = 1'b1;
      @(negedge clk) chan_on_set = 1'b0;
   endtask

   task automatic pulse_sw();
      @(negedge clk) sw_trig_set = 1'b1;
      @(negedge clk) sw_trig_set = 1'b0;
   endtask

   task automatic pulse_hw(input int idx);
      @(negedge clk) hw_req = 7'(1 << idx);
      @(negedge clk) hw_req = 7'd0;
   endtask

   // idle window: afterwards every expected transfer must have been seen
   task automatic settle(input string req);
      repeat (30) @(negedge clk);
      check({req, " scoreboard drained"}, sb.size(), 0);
      sb.delete();
   endtask

   // monitor and bus/beat responder, all at the falling edge
   int  beat_cnt = 0;
   bit  prev_bus = 1'b0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (beat_req) beat_cnt++;
         if (tc_irq && !(prev_bus && !bus_req)) begin
            check("R9 stray tc_irq", 1, 0);
         end
         if (prev_bus && !bus_req) begin
            xfers++;
            if (sb.size() == 0) begin
               check("R6/R7 unexpected transfer", 1, 0);
            end else begin
               exp_t e;
               e = sb.pop_front();
               check("R8 cur_cnt", int'(cur_cnt), e.cnt);
               check("R9 tc_irq", int'(tc_irq), int'(e.tc));
               check("R10 chan_on", int'(chan_on), int'(e.on));
               check("R4 beats", beat_cnt, e.beats);
            end
            beat_cnt = 0;
         end
         prev_bus  = bus_req;
         bus_gnt   = bus_req;
         beat_done = beat_req;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         errs++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
         $finish;
      end
   end

   initial begin
      int base;
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1 bus_req", int'(bus_req), 0);
      check("R1 beat_req", int'(beat_req), 0);
      check("R1 chan_on", int'(chan_on), 0);
      check("R1 sw_pend", int'(sw_pend), 0);
      check("R1 tc_irq", int'(tc_irq), 0);
      check("R1 cur_cnt", int'(cur_cnt), 0);
      rst_n = 1'b1;

      // per-request, software, auto-reload, single beat, init 3
      cfg_init_cnt = 20'd3;
      pulse_on();
      push(2, 0, 1, 1);
      pulse_sw();
      settle("R6 first");
      check("R2 sw_pend cleared", int'(sw_pend), 0);
      push(1, 0, 1, 1); pulse_sw(); settle("R6 second");
      push(0, 1, 1, 1); pulse_sw(); settle("R9 terminal");
      check("R10 chan_on kept with auto-reload", int'(chan_on), 1);
      push(2, 0, 1, 1); pulse_sw(); settle("R8 reload");

      // whole-count, burst of four, stop at zero; count 2 is not reloaded
      cfg_whole = 1'b1; cfg_burst4 = 1'b1; cfg_stop_at_tc = 1'b1; cfg_init_cnt = 20'd9;
      push(1, 0, 1, 4); push(0, 1, 0, 4);
      pulse_sw();
      settle("R7 whole run");
      check("R10 chan_on cleared", int'(chan_on), 0);

      // start while channel is off: kept pending, nothing moves
      base = xfers;
      pulse_sw();
      repeat (15) @(negedge clk);
      check("R2 no start while off", xfers - base, 0);
      check("R2 sw_pend held while off", int'(sw_pend), 1);
      cfg_init_cnt = 20'd2;
      push(1, 0, 1, 4); push(0, 1, 0, 4);
      pulse_on();
      settle("R7 whole run after enable");

      // hardware start, per-request, source 5
      cfg_whole = 1'b0; cfg_burst4 = 1'b0; cfg_stop_at_tc = 1'b0;
      cfg_hw_trig = 1'b1; cfg_src_sel = 3'd5; cfg_init_cnt = 20'd5;
      pulse_on();
      base = xfers;
      pulse_hw(3);
      repeat (15) @(negedge clk);
      check("R3 unselected line ignored", xfers - base, 0);
      check("R3 count untouched", int'(cur_cnt), 0);
      push(4, 0, 1, 1);
      pulse_hw(5);
      settle("R3 selected line");

      // reserved source in hardware mode
      cfg_src_sel = 3'd7;
      @(negedge clk);
      check("R11 err on src 7", int'(cfg_err), 1);
      base = xfers;
      @(negedge clk) hw_req = 7'h7F;
      repeat (10) @(negedge clk);
      hw_req = 7'd0;
      check("R11 no start on err", xfers - base, 0);

      // source select ignored in software mode
      cfg_hw_trig = 1'b0;
      @(negedge clk);
      check("R3 src ignored in sw mode", int'(cfg_err), 0);

      // reserved data size blocks a software start, which stays pending
      cfg_dsize = 2'b11;
      @(negedge clk);
      check("R11 err on dsize 3", int'(cfg_err), 1);
      base = xfers;
      pulse_sw();
      repeat (10) @(negedge clk);
      check("R11 no start on dsize err", xfers - base, 0);
      check("R11 pend kept", int'(sw_pend), 1);
      push(3, 0, 1, 1);
      cfg_dsize = 2'b00;
      settle("R11 start after fix");

      // bytes per beat
      for (int d = 0; d < 4; d++) begin
         cfg_dsize = 2'(d);
         @(negedge clk);
         check("R12 beat_bytes", int'(beat_bytes), (d == 0) ? 1 : (d == 1) ? 2 : (d == 2) ? 4 : 0);
      end

      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
   end
endmodule